// File: doc/BRIEF.md
# Scalar Integer ALU with Condition Flag

This block is the execution stage of a scalar integer pipeline. Each cycle it may accept one operation: a 5-bit opcode and two 64-bit source operands. One clock edge later it presents a 64-bit result and an updated single-bit condition flag. Operations that work on 32 bits use only the low halves of the sources and return a zero-extended result.

The condition flag lives inside the block. Some operations read it: add-with-carry and the two select forms. Some operations write it. Each opcode follows its own rule for the flag: a carry, a borrow, a signed overflow, a nonzero test, or leaving it untouched. Shift amounts and bit-field positions come from masked sub-fields of the second source. Operand fetch, the register file and instruction word decoding all sit outside the block.

Top module: `scalar_alu`

## Requirements
- R1: A synchronous reset clears the flag, the result and `outValid` to 0.
- R2: When `inValid` is 1, the result and the flag update on the next rising edge and `outValid` is 1 in the following cycle. When `inValid` is 0, the result and the flag hold and `outValid` is 0.
- R3: Opcode 0 is unsigned add, and the flag becomes the carry out of bit 31. Opcode 2 is unsigned subtract (src0 - src1), and the flag becomes the borrow (src0 < src1).
- R4: Opcode 1 is signed add. Its flag is 1 when both operands have the same sign and the sum's sign differs from src0's. Opcode 3 is signed subtract. Its flag is 1 when the operand signs differ and the difference's sign differs from src0's.
- R5: Opcode 4 computes src0 + src1 + flag. The new flag is the OR of the carry of the first sum and the carry of adding the old flag.
- R6: Opcodes 5, 6, 7 and 8 are signed min, signed max, unsigned min and unsigned max. Opcode 9 is the low 32 bits of the signed product. None of these changes the flag.
- R7: Opcodes 10, 11 and 12 are logical left shift, logical right shift and arithmetic right shift of src0. The shift amount is src1[4:0]. The flag becomes (result != 0).
- R8: Opcodes 13, 14 and 15 are the 32-bit AND, OR and XOR. The flag becomes (result != 0). Every 32-bit operation returns 0 in result[63:32].
- R9: Opcodes 16 to 22 are 64-bit operations, in this order: AND, OR, XOR, src0 AND NOT src1, src0 OR NOT src1, NAND and NOR. The flag is 1 when any of the 64 result bits is 1.
- R10: Opcode 23 selects the low half of src0 when the flag is 1 and the low half of src1 otherwise. Opcode 24 does the same on all 64 bits. Neither changes the flag.
- R11: Opcode 25 extracts a zero-extended field from src0. The field starts at bit src1[4:0] and is src1[22:16] bits wide. A width of 0 gives 0. Only bits up to bit 31 are returned. The flag becomes (result != 0).
- R12: Opcode 26 returns ((1 << src0[4:0]) - 1) << src1[4:0], truncated to 32 bits, and leaves the flag unchanged.
- R13: Opcodes 27 to 31 return 0 and leave the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operation present this cycle |
| opCode | input | 5 | Operation code |
| src0 | input | 64 | First source operand |
| src1 | input | 64 | Second source operand |
| result | output | 64 | Registered destination value |
| scc | output | 1 | Condition flag |
| outValid | output | 1 | Result updated on the last edge |

## Verification
Five properties hold on every cycle:
- Idle cycles preserve the result and the flag.
- `outValid` follows `inValid`.
- The add-with-carry sum and flag together form one 33-bit addition.
- Flag-preserving opcodes never touch the flag, and nonzero-rule opcodes set the flag exactly when the result is nonzero.
- 32-bit results have a zero upper half, and the 64-bit select picks its operand from the prior flag.

Only the bench scenarios show the actual values:
- the signed-overflow rules, borrow, shift and extract semantics, and the mask formula;
- the extract corner cases, where the width is 0 or larger than 32 and the field runs past bit 31;
- the behaviour of the undefined opcodes.

The bench sweeps every opcode over a fixed set of edge-case operands, with both flag values as the starting state.

// File: rtl/salu_pkg.sv
package salu_pkg;

  typedef enum logic [4:0] {
    OP_ADD_U  = 5'd0,  OP_ADD_S  = 5'd1,  OP_SUB_U  = 5'd2,  OP_SUB_S  = 5'd3,
    OP_ADDC   = 5'd4,  OP_MIN_S  = 5'd5,  OP_MAX_S  = 5'd6,  OP_MIN_U  = 5'd7,
    OP_MAX_U  = 5'd8,  OP_MUL    = 5'd9,  OP_SHL    = 5'd10, OP_SHR    = 5'd11,
    OP_SAR    = 5'd12, OP_AND32  = 5'd13, OP_OR32   = 5'd14, OP_XOR32  = 5'd15,
    OP_AND64  = 5'd16, OP_OR64   = 5'd17, OP_XOR64  = 5'd18, OP_ANDN64 = 5'd19,
    OP_ORN64  = 5'd20, OP_NAND64 = 5'd21, OP_NOR64  = 5'd22, OP_SEL32  = 5'd23,
    OP_SEL64  = 5'd24, OP_BFE    = 5'd25, OP_BFM    = 5'd26
  } sOp_e;

  typedef enum logic [3:0] {
    RES_ZERO, RES_ADD, RES_SUB, RES_ADDC, RES_MIN_S, RES_MAX_S, RES_MIN_U,
    RES_MAX_U, RES_MUL, RES_SHL, RES_SHR, RES_SAR, RES_BFE, RES_BFM,
    RES_LOGIC, RES_SEL
  } resSel_e;

  typedef enum logic [2:0] {
    SCC_KEEP, SCC_CARRY, SCC_BORROW, SCC_OVF_ADD, SCC_OVF_SUB,
    SCC_CARRY_ADDC, SCC_NONZERO
  } sccSrc_e;

  typedef enum logic [1:0] { LF_AND, LF_OR, LF_XOR } logicFn_e;

  typedef struct packed {
    resSel_e  resSel;
    sccSrc_e  sccSrc;
    logicFn_e logicFn;
    logic     invB;
    logic     invOut;
    logic     wide;
  } aluCtrl_t;

endpackage

// File: rtl/salu_ctrl.sv
module salu_ctrl
  import salu_pkg::*;
(
  input  logic [4:0] opCode,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl.resSel  = RES_ZERO;
    ctrl.sccSrc  = SCC_KEEP;
    ctrl.logicFn = LF_AND;
    ctrl.invB    = 1'b0;
    ctrl.invOut  = 1'b0;
    ctrl.wide    = 1'b0;
    case (opCode)
      OP_ADD_U:  begin ctrl.resSel = RES_ADD;  ctrl.sccSrc = SCC_CARRY;      end
      OP_ADD_S:  begin ctrl.resSel = RES_ADD;  ctrl.sccSrc = SCC_OVF_ADD;    end
      OP_SUB_U:  begin ctrl.resSel = RES_SUB;  ctrl.sccSrc = SCC_BORROW;     end
      OP_SUB_S:  begin ctrl.resSel = RES_SUB;  ctrl.sccSrc = SCC_OVF_SUB;    end
      OP_ADDC:   begin ctrl.resSel = RES_ADDC; ctrl.sccSrc = SCC_CARRY_ADDC; end
      OP_MIN_S:  ctrl.resSel = RES_MIN_S;
      OP_MAX_S:  ctrl.resSel = RES_MAX_S;
      OP_MIN_U:  ctrl.resSel = RES_MIN_U;
      OP_MAX_U:  ctrl.resSel = RES_MAX_U;
      OP_MUL:    ctrl.resSel = RES_MUL;
      OP_SHL:    begin ctrl.resSel = RES_SHL; ctrl.sccSrc = SCC_NONZERO; end
      OP_SHR:    begin ctrl.resSel = RES_SHR; ctrl.sccSrc = SCC_NONZERO; end
      OP_SAR:    begin ctrl.resSel = RES_SAR; ctrl.sccSrc = SCC_NONZERO; end
      OP_AND32:  begin ctrl.resSel = RES_LOGIC; ctrl.sccSrc = SCC_NONZERO; ctrl.logicFn = LF_AND; end
      OP_OR32:   begin ctrl.resSel = RES_LOGIC; ctrl.sccSrc = SCC_NONZERO; ctrl.logicFn = LF_OR;  end
      OP_XOR32:  begin ctrl.resSel = RES_LOGIC; ctrl.sccSrc = SCC_NONZERO; ctrl.logicFn = LF_XOR; end
      OP_AND64:  begin ctrl.resSel = RES_LOGIC; ctrl.sccSrc = SCC_NONZERO; ctrl.logicFn = LF_AND; ctrl.wide = 1'b1; end
      OP_OR64:   begin ctrl.resSel = RES_LOGIC; ctrl.sccSrc = SCC_NONZERO; ctrl.logicFn = LF_OR;  ctrl.wide = 1'b1; end
      OP_XOR64:  begin ctrl.resSel = RES_LOGIC; ctrl.sccSrc = SCC_NONZERO; ctrl.logicFn = LF_XOR; ctrl.wide = 1'b1; end
      OP_ANDN64: begin ctrl.resSel = RES_LOGIC; ctrl.sccSrc = SCC_NONZERO; ctrl.logicFn = LF_AND; ctrl.wide = 1'b1; ctrl.invB = 1'b1; end
      OP_ORN64:  begin ctrl.resSel = RES_LOGIC; ctrl.sccSrc = SCC_NONZERO; ctrl.logicFn = LF_OR;  ctrl.wide = 1'b1; ctrl.invB = 1'b1; end
      OP_NAND64: begin ctrl.resSel = RES_LOGIC; ctrl.sccSrc = SCC_NONZERO; ctrl.logicFn = LF_AND; ctrl.wide = 1'b1; ctrl.invOut = 1'b1; end
      OP_NOR64:  begin ctrl.resSel = RES_LOGIC; ctrl.sccSrc = SCC_NONZERO; ctrl.logicFn = LF_OR;  ctrl.wide = 1'b1; ctrl.invOut = 1'b1; end
      OP_SEL32:  ctrl.resSel = RES_SEL;
      OP_SEL64:  begin ctrl.resSel = RES_SEL; ctrl.wide = 1'b1; end
      OP_BFE:    begin ctrl.resSel = RES_BFE; ctrl.sccSrc = SCC_NONZERO; end
      OP_BFM:    ctrl.resSel = RES_BFM;
      default:   ctrl.resSel = RES_ZERO; // R13
    endcase
  end

endmodule

// File: rtl/salu_dpath.sv
module salu_dpath
  import salu_pkg::*;
#(
  parameter int WORD = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  aluCtrl_t          ctrl,
  input  logic [2*WORD-1:0] src0,
  input  logic [2*WORD-1:0] src1,
  output logic [2*WORD-1:0] resQ,
  output logic              sccQ,
  output logic              vldQ
);

  localparam int DWORD     = 2 * WORD;
  localparam int SHW       = $clog2(WORD);
  localparam int WID_LSB   = 16;
  localparam int WID_BITS  = SHW + 2;
  localparam int MSB       = WORD - 1;

  logic [WORD-1:0] a, b;
  assign a = src0[WORD-1:0];
  assign b = src1[WORD-1:0];

  logic [WORD:0]     sumAB, sumC;
  logic [WORD-1:0]   diff, mulLo, shl, shr, sar, bfeRes, bfmRes, fieldMask;
  logic [SHW-1:0]    shAmt;
  logic [WID_BITS-1:0] fieldWid;
  logic [WORD-1:0]   one;
  logic [DWORD-1:0]  bOp, logicRes, selRes, nxtRes;
  logic              nxtScc;

  assign one    = {{(WORD-1){1'b0}}, 1'b1};
  assign sumAB  = {1'b0, a} + {1'b0, b};
  assign sumC   = {1'b0, sumAB[WORD-1:0]} + {{WORD{1'b0}}, sccQ};
  assign diff   = a - b;
  assign mulLo  = a * b;
  assign shAmt  = b[SHW-1:0];
  assign shl    = a << shAmt;
  assign shr    = a >> shAmt;
  assign sar    = WORD'($signed(a) >>> shAmt);

  assign fieldWid  = b[WID_LSB +: WID_BITS];
  assign fieldMask = (fieldWid >= WID_BITS'(WORD)) ? {WORD{1'b1}}
                   : ((one << fieldWid[SHW-1:0]) - one);
  assign bfeRes    = shr & fieldMask;
  assign bfmRes    = ((one << a[SHW-1:0]) - one) << shAmt;

  always_comb begin
    bOp = ctrl.invB ? ~src1 : src1;
    case (ctrl.logicFn)
      LF_OR:   logicRes = src0 | bOp;
      LF_XOR:  logicRes = src0 ^ bOp;
      default: logicRes = src0 & bOp;
    endcase
    if (ctrl.invOut) logicRes = ~logicRes;
    if (!ctrl.wide)  logicRes[DWORD-1:WORD] = '0;
    selRes = sccQ ? src0 : src1;
    if (!ctrl.wide)  selRes[DWORD-1:WORD] = '0;
  end

  always_comb begin
    nxtRes = '0;
    case (ctrl.resSel)
      RES_ADD:   nxtRes[WORD-1:0] = sumAB[WORD-1:0];
      RES_SUB:   nxtRes[WORD-1:0] = diff;
      RES_ADDC:  nxtRes[WORD-1:0] = sumC[WORD-1:0];
      RES_MIN_S: nxtRes[WORD-1:0] = ($signed(a) < $signed(b)) ? a : b;
      RES_MAX_S: nxtRes[WORD-1:0] = ($signed(a) < $signed(b)) ? b : a;
      RES_MIN_U: nxtRes[WORD-1:0] = (a < b) ? a : b;
      RES_MAX_U: nxtRes[WORD-1:0] = (a < b) ? b : a;
      RES_MUL:   nxtRes[WORD-1:0] = mulLo;
      RES_SHL:   nxtRes[WORD-1:0] = shl;
      RES_SHR:   nxtRes[WORD-1:0] = shr;
      RES_SAR:   nxtRes[WORD-1:0] = sar;
      RES_BFE:   nxtRes[WORD-1:0] = bfeRes;
      RES_BFM:   nxtRes[WORD-1:0] = bfmRes;
      RES_LOGIC: nxtRes = logicRes;
      RES_SEL:   nxtRes = selRes;
      default:   nxtRes = '0;
    endcase
  end

  always_comb begin
    case (ctrl.sccSrc)
      SCC_CARRY:      nxtScc = sumAB[WORD];
      SCC_BORROW:     nxtScc = (a < b);
      SCC_OVF_ADD:    nxtScc = (a[MSB] == b[MSB]) && (sumAB[MSB] != a[MSB]);
      SCC_OVF_SUB:    nxtScc = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
      SCC_CARRY_ADDC: nxtScc = sumAB[WORD] | sumC[WORD];
      SCC_NONZERO:    nxtScc = |nxtRes;
      default:        nxtScc = sccQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resQ <= '0;
      sccQ <= 1'b0;
      vldQ <= 1'b0;
    end else begin
      vldQ <= inValid;
      if (inValid) begin
        resQ <= nxtRes;
        sccQ <= nxtScc;
      end
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(resQ) && $stable(sccQ) && !vldQ); // R2
  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    inValid |=> vldQ); // R2
  AST_ADDC_SUM: assert property (@(posedge clk) disable iff (rst)
    (inValid && ctrl.resSel == RES_ADDC) |=>
      ({sccQ, resQ[WORD-1:0]} == ({1'b0, $past(a)} + {1'b0, $past(b)} + {{WORD{1'b0}}, $past(sccQ)}))); // R5
  AST_KEEP_FLAG: assert property (@(posedge clk) disable iff (rst)
    (inValid && ctrl.sccSrc == SCC_KEEP) |=> (sccQ == $past(sccQ))); // R6
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
    (inValid && !ctrl.wide) |=> (resQ[DWORD-1:WORD] == '0)); // R8
  AST_NONZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (inValid && ctrl.sccSrc == SCC_NONZERO) |=> (sccQ == (resQ != '0))); // R9
  AST_SEL_WIDE: assert property (@(posedge clk) disable iff (rst)
    (inValid && ctrl.resSel == RES_SEL && ctrl.wide) |=>
      (resQ == ($past(sccQ) ? $past(src0) : $past(src1)))); // R10

endmodule

// File: rtl/scalar_alu.sv
module scalar_alu
  import salu_pkg::*;
#(
  parameter int WORD = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [4:0]        opCode,
  input  logic [2*WORD-1:0] src0,
  input  logic [2*WORD-1:0] src1,
  output logic [2*WORD-1:0] result,
  output logic              scc,
  output logic              outValid
);

  aluCtrl_t ctrl;

  salu_ctrl uCtrl (
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  salu_dpath #(.WORD(WORD)) uDpath (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .ctrl    (ctrl),
    .src0    (src0),
    .src1    (src1),
    .resQ    (result),
    .sccQ    (scc),
    .vldQ    (outValid)
  );

endmodule

// File: tb/tb_scalar_alu.sv
`timescale 1ns/1ps
module tb_scalar_alu;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [4:0]  opCode;
  logic [63:0] src0, src1;
  logic [63:0] result;
  logic        scc, outValid;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic expScc;
  logic [63:0] lastRes;

  always #2 clk = ~clk;

  scalar_alu dut (
    .clk(clk), .rst(rst), .inValid(inValid), .opCode(opCode),
    .src0(src0), .src1(src1), .result(result), .scc(scc), .outValid(outValid)
  );

  function automatic string tagOf(input int op);
    if (op == 0 || op == 2) return "R3";
    if (op == 1 || op == 3) return "R4";
    if (op == 4) return "R5";
    if (op >= 5 && op <= 9) return "R6";
    if (op >= 10 && op <= 12) return "R7";
    if (op >= 13 && op <= 15) return "R8";
    if (op >= 16 && op <= 22) return "R9";
    if (op == 23 || op == 24) return "R10";
    if (op == 25) return "R11";
    if (op == 26) return "R12";
    return "R13";
  endfunction

  function automatic void model(input int op, input logic [63:0] x, input logic [63:0] y,
                                input logic sIn, output logic [63:0] r, output logic sOut);
    logic [31:0] a, b, t;
    logic [32:0] w;
    logic [63:0] p;
    int off, wid, sh;
    a = x[31:0]; b = y[31:0]; r = '0; sOut = sIn;
    case (op)
      0: begin w = {1'b0, a} + {1'b0, b}; r[31:0] = w[31:0]; sOut = w[32]; end
      1: begin t = a + b; r[31:0] = t; sOut = (a[31] == b[31]) && (t[31] != a[31]); end
      2: begin r[31:0] = a - b; sOut = (a < b); end
      3: begin t = a - b; r[31:0] = t; sOut = (a[31] != b[31]) && (t[31] != a[31]); end
      4: begin w = {1'b0, a} + {1'b0, b} + {32'd0, sIn}; r[31:0] = w[31:0]; sOut = w[32]; end
      5: r[31:0] = ($signed(a) < $signed(b)) ? a : b;
      6: r[31:0] = ($signed(a) > $signed(b)) ? a : b;
      7: r[31:0] = (a < b) ? a : b;
      8: r[31:0] = (a > b) ? a : b;
      9: begin p = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b}); r[31:0] = p[31:0]; end
      10: r[31:0] = a << b[4:0];
      11: r[31:0] = a >> b[4:0];
      12: r[31:0] = $unsigned($signed(a) >>> b[4:0]);
      13: r[31:0] = a & b;
      14: r[31:0] = a | b;
      15: r[31:0] = a ^ b;
      16: r = x & y;
      17: r = x | y;
      18: r = x ^ y;
      19: r = x & ~y;
      20: r = x | ~y;
      21: r = ~(x & y);
      22: r = ~(x | y);
      23: r[31:0] = sIn ? a : b;
      24: r = sIn ? x : y;
      25: begin
        off = int'(b[4:0]); wid = int'(b[22:16]);
        for (int k = 0; k < 32; k++)
          if (k < wid && off + k < 32) r[k] = a[off + k];
      end
      26: begin
        wid = int'(a[4:0]); sh = int'(b[4:0]);
        for (int k = 0; k < 32; k++)
          if (k >= sh && k < sh + wid) r[k] = 1'b1;
      end
      default: r = '0;
    endcase
    if ((op <= 15) || op == 25 || op == 10 || op == 11 || op == 12) begin
      if (op >= 10 && op <= 15) sOut = (r != 0);
      if (op == 25) sOut = (r != 0);
    end
    if (op >= 16 && op <= 22) sOut = (r != 0);
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic runOp(input int op, input logic [63:0] x, input logic [63:0] y);
    logic [63:0] er;
    logic es;
    model(op, x, y, expScc, er, es);
    @(negedge clk);
    inValid = 1'b1; opCode = 5'(op); src0 = x; src1 = y;
    @(negedge clk);
    inValid = 1'b0;
    check(tagOf(op), "result", result, er);
    check(tagOf(op), "flag", {63'd0, scc}, {63'd0, es});
    check("R2", "outValid", {63'd0, outValid}, 64'd1);
    expScc = es;
    lastRes = er;
  endtask

  logic [63:0] pats [12];

  initial begin
    pats[0]  = 64'h0;
    pats[1]  = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2]  = 64'h1;
    pats[3]  = 64'h0000_0000_8000_0000;
    pats[4]  = 64'h0000_0000_7FFF_FFFF;
    pats[5]  = 64'h0000_0000_FFFF_FFFF;
    pats[6]  = 64'hFFFF_FFFF_0000_0000;
    pats[7]  = 64'h0000_0000_0013_0007;
    pats[8]  = 64'h0000_0000_0005_001C;
    pats[9]  = 64'h0000_0000_0040_0003;
    pats[10] = 64'h1234_5678_9ABC_DEF0;
    pats[11] = 64'h0000_0000_0000_0021;

    rst = 1'b1; inValid = 1'b0; opCode = '0; src0 = '0; src1 = '0;
    expScc = 1'b0; lastRes = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "result", result, 64'd0);
    check("R1", "flag", {63'd0, scc}, 64'd0);
    check("R1", "outValid", {63'd0, outValid}, 64'd0);
    rst = 1'b0;

    // R11 width 0 and overflowing field
    runOp(25, 64'hFFFF_FFFF, 64'h0000_0000_0000_0005);
    check("R11", "zero width", result, 64'd0);
    runOp(25, 64'hF000_0000, 64'h0000_0000_0008_001C);
    check("R11", "field past bit 31", result, 64'h0000_000F);

    for (int op = 0; op < 32; op++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          for (int s = 0; s < 2; s++) begin
            if (s == 0) runOp(0, 64'd0, 64'd0);
            else        runOp(0, 64'hFFFF_FFFF, 64'd1);
            runOp(op, pats[i], pats[j]);
          end

    // R2: idle cycles hold state
    begin
      logic [31:0] lfsr = 32'hACE1_1234;
      for (int n = 0; n < 1500; n++) begin
        logic [63:0] x, y;
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        x = {lfsr, lfsr ^ 32'h5A5A_0F0F};
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        y = {~lfsr, lfsr};
        runOp(int'(lfsr[4:0]), x, y);
        if (n % 50 == 0) begin
          opCode = 5'd0; src0 = ~x; src1 = y;
          @(negedge clk);
          check("R2", "idle result", result, lastRes);
          check("R2", "idle flag", {63'd0, scc}, {63'd0, expScc});
          check("R2", "idle outValid", {63'd0, outValid}, 64'd0);
        end
      end
    end

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule